// File: doc/BRIEF.md
# Character LCD Timed Write Engine

This block sits between a word source and the parallel bus of a character LCD controller with the common 44780-style command set. It takes one 9-bit word per handshake. Bit 8 selects the register: 0 is a command and 1 is data. Bits 7:0 are the value to write. It shifts each word out on the LCD bus with a clean enable strobe. The read/write line is held low and the busy flag is never read. Completion of each write is guaranteed only by a fixed wait that follows it.

The wait length comes from the written value. A command whose highest set bit is bit 1 or bit 0 is a clear or home operation, and it gets the long wait. Every other command and every data write gets the short wait. Both waits are derated for the slowest internal oscillator of the display, with extra margin for supply and temperature, and are given as compile-time nanosecond parameters. The all-zero command has no defined meaning on the display, so it is turned into a wait-only slot: nothing is strobed and the long wait passes.

The bus width is chosen per word. In 8-bit mode the whole byte is sent in one strobe. In 4-bit mode the upper nibble is strobed first and the lower nibble follows. A sideband flag makes a single upper-nibble strobe, which the upstream sequencer uses during start-up.

Top module: `lcd_timed_writer`

## Requirements
- R1: After synchronous reset, in_ready is 1, lcd_en is 0 and lcd_rs is 0, and lcd_data is 0x00.
- R2: lcd_rw is 0 at all times.
- R3: In 8-bit mode (in_mode4=0), a non-idle word produces exactly one enable pulse. During that pulse lcd_data equals in_word[7:0] and lcd_rs equals in_word[8]. The in_nibble flag has no effect in this mode.
- R4: In 4-bit mode (in_mode4=1, in_nibble=0), a non-idle word produces two enable pulses. The first carries in_word[7:4] on lcd_data[7:4] and the second carries in_word[3:0] on lcd_data[7:4]. lcd_data[3:0] is 0 during both pulses, and lcd_rs equals in_word[8] for both.
- R5: In 4-bit mode with in_nibble=1, only one pulse is made, carrying in_word[7:4] on lcd_data[7:4]. It is always followed by the short wait.
- R6: Each enable pulse is high for EN cycles. lcd_data and lcd_rs stay unchanged from at least one cycle before the rising edge until after the falling edge.
- R7: A command (in_word[8]=0) whose value is 0x01, 0x02 or 0x03 is followed by the long wait of SLOW cycles.
- R8: A command with a value of 0x04 or more, and every data word (in_word[8]=1, including 0x00), is followed by the short wait of FAST cycles.
- R9: The word 0x000 (a command of value 0) produces no enable pulse, and in_ready stays low for exactly SLOW cycles.
- R10: in_ready falls in the cycle after acceptance. It stays low for SETUP+EN+HOLD+wait cycles for one strobe, and for SETUP+EN+HOLD+GAP+EN+HOLD+wait cycles for two strobes. Words offered while in_ready is low are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | Engine idle; the offered word is taken on this edge |
| in_word | input | 9 | Bit 8 register select, bits 7:0 value |
| in_mode4 | input | 1 | 1 selects the 4-bit bus for this word |
| in_nibble | input | 1 | In 4-bit mode, send only the upper nibble |
| lcd_rs | output | 1 | Register select to the display |
| lcd_rw | output | 1 | Read/write, held low |
| lcd_en | output | 1 | Enable strobe |
| lcd_data | output | 8 | Display data lines D7..D0 |

## Verification
Random words are drawn from classes weighted toward the decode edges: values 0x00 to 0x03, values just above them, wide commands and data words. Bus mode and the nibble flag are also random. Running the same value as command and as data separates the register-select rule from the value decode. Values 0x01 to 0x04 tell the long-wait boundary apart. Command 0x00 next to data 0x00 separates the idle slot from an ordinary zero write. Per-pulse data capture in 4-bit mode shows whether the nibbles come out in order, and the total busy-cycle count catches any error in the delay or the gap.

// File: rtl/lcd_timed_writer.sv
module lcd_timed_writer #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int SETUP_NS = 100,
  parameter int EN_NS    = 500,
  parameter int HOLD_NS  = 20,
  parameter int GAP_NS   = 1200,
  parameter int FAST_NS  = 58_000,
  parameter int SLOW_NS  = 2_400_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [8:0] in_word,
  input  logic       in_mode4,
  input  logic       in_nibble,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en,
  output logic [7:0] lcd_data
);

  function automatic int ns2cyc(input int ns);
    longint c;
    c = (longint'(ns) * longint'(CLK_HZ) + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  localparam int SETUP_C = ns2cyc(SETUP_NS);
  localparam int EN_C    = ns2cyc(EN_NS);
  localparam int HOLD_C  = ns2cyc(HOLD_NS);
  localparam int GAP_C   = ns2cyc(GAP_NS);
  localparam int FAST_C  = ns2cyc(FAST_NS);
  localparam int SLOW_C  = ns2cyc(SLOW_NS);
  localparam int M1      = (SLOW_C > FAST_C) ? SLOW_C : FAST_C;
  localparam int M2      = (GAP_C > SETUP_C) ? GAP_C : SETUP_C;
  localparam int M3      = (EN_C > HOLD_C) ? EN_C : HOLD_C;
  localparam int M4      = (M1 > M2) ? M1 : M2;
  localparam int MAXC    = (M4 > M3) ? M4 : M3;
  localparam int CW      = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_PULSE, S_HOLD, S_WAIT} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic        rs_q, half_q, lo_q, single_q, slow_q;
  logic [7:0]  byte_q;

  wire take     = in_valid && (st == S_IDLE);
  wire idle_cmd = !in_word[8] && (in_word[7:0] == 8'h00);
  wire long_cmd = !in_word[8] && (in_word[7:2] == 6'd0) && !(in_mode4 && in_nibble);
  wire last     = (cnt == '0);

  assign in_ready = (st == S_IDLE);
  assign lcd_en   = (st == S_PULSE);
  assign lcd_rw   = 1'b0;
  assign lcd_rs   = rs_q;
  assign lcd_data = half_q ? {(lo_q ? byte_q[3:0] : byte_q[7:4]), 4'h0} : byte_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      rs_q     <= 1'b0;
      byte_q   <= 8'h00;
      half_q   <= 1'b0;
      lo_q     <= 1'b0;
      single_q <= 1'b0;
      slow_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          rs_q     <= in_word[8];
          byte_q   <= in_word[7:0];
          half_q   <= in_mode4;
          single_q <= in_mode4 && in_nibble;
          slow_q   <= long_cmd;
          lo_q     <= 1'b0;
          if (idle_cmd) begin
            st  <= S_WAIT;
            cnt <= CW'(SLOW_C - 1);
          end else begin
            st  <= S_SETUP;
            cnt <= CW'(SETUP_C - 1);
          end
        end
        S_SETUP: if (last) begin
          st  <= S_PULSE;
          cnt <= CW'(EN_C - 1);
        end else cnt <= cnt - 1'b1;
        S_PULSE: if (last) begin
          st  <= S_HOLD;
          cnt <= CW'(HOLD_C - 1);
        end else cnt <= cnt - 1'b1;
        S_HOLD: if (last) begin
          if (half_q && !lo_q && !single_q) begin
            lo_q <= 1'b1;
            st   <= S_SETUP;
            cnt  <= CW'(GAP_C - 1);
          end else begin
            st  <= S_WAIT;
            cnt <= slow_q ? CW'(SLOW_C - 1) : CW'(FAST_C - 1);
          end
        end else cnt <= cnt - 1'b1;
        S_WAIT: if (last) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lcd_timed_writer_sva.sv
module lcd_timed_writer_sva (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic [8:0] in_word,
  input logic       lcd_rs,
  input logic       lcd_rw,
  input logic       lcd_en,
  input logic [7:0] lcd_data
);

  p_rw_low_r2: assert property (@(posedge clk) disable iff (rst) !lcd_rw);

  p_ready_falls_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> !in_ready);

  p_quiet_when_ready_r10: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !lcd_en);

  p_setup_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_en) |-> $stable(lcd_data) && $stable(lcd_rs));

  p_steady_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    lcd_en && $past(lcd_en) |-> $stable(lcd_data) && $stable(lcd_rs));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(lcd_en) |-> $stable(lcd_data) && $stable(lcd_rs));

  p_idle_no_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && (in_word == 9'h000) |=> !lcd_en);

endmodule

bind lcd_timed_writer lcd_timed_writer_sva u_sva (.*);

// File: tb/lcd_timed_writer_tb.sv
module lcd_timed_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int S = 2, E = 5, H = 2, G = 10, F = 30, L = 100;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_mode4 = 0, in_nibble = 0;
  logic [8:0] in_word = '0;
  logic in_ready, lcd_rs, lcd_rw, lcd_en;
  logic [7:0] lcd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_timed_writer #(
    .CLK_HZ(100_000_000), .SETUP_NS(20), .EN_NS(50), .HOLD_NS(20),
    .GAP_NS(100), .FAST_NS(300), .SLOW_NS(1000)
  ) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_mode4(in_mode4), .in_nibble(in_nibble),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en), .lcd_data(lcd_data)
  );

  int checks = 0, fails = 0, cyc = 0;
  int busy_n, pulse_n, hi_n, rw_bad;
  int pw[2];
  logic [7:0] pd[2];
  logic prs[2];
  logic en_prev = 0;

  always @(negedge clk) begin
    cyc++;
    if (!in_ready) busy_n++;
    if (lcd_rw) rw_bad++;
    if (lcd_en && !en_prev) begin
      if (pulse_n < 2) begin pd[pulse_n] = lcd_data; prs[pulse_n] = lcd_rs; end
      pulse_n++;
      hi_n = 0;
    end
    if (lcd_en) hi_n++;
    if (!lcd_en && en_prev && pulse_n >= 1 && pulse_n <= 2) pw[pulse_n-1] = hi_n;
    en_prev = lcd_en;
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_pulses(input logic [8:0] w, input logic m4, input logic nb);
    if (w == 9'h000) return 0;
    return (m4 && !nb) ? 2 : 1;
  endfunction

  function automatic int exp_busy(input logic [8:0] w, input logic m4, input logic nb);
    int d;
    if (w == 9'h000) return L;
    d = (!w[8] && w[7:2] == 0 && !(m4 && nb)) ? L : F;
    return (exp_pulses(w, m4, nb) == 2) ? (S+E+H+G+E+H+d) : (S+E+H+d);
  endfunction

  task automatic send(input logic [8:0] w, input logic m4, input logic nb);
    int np;
    string rq;
    @(negedge clk); #1;
    busy_n = 0; pulse_n = 0; pw[0] = 0; pw[1] = 0;
    in_word = w; in_mode4 = m4; in_nibble = nb; in_valid = 1;
    @(negedge clk); #1;
    in_word = ~w;
    in_valid = 1;
    do begin @(negedge clk); #1; end while (!in_ready);
    in_valid = 0;
    @(negedge clk); #1;
    np = exp_pulses(w, m4, nb);
    rq = (w == 9'h000) ? "R9" : (!w[8] && w[7:2] == 0 && !(m4 && nb)) ? "R7" : "R8";
    check(rq, busy_n, exp_busy(w, m4, nb), "busy cycles (R10)");
    check(m4 ? (nb ? "R5" : "R4") : "R3", pulse_n, np, "pulse count");
    if (np == 1 && m4) begin
      check("R5", pd[0], {w[7:4], 4'h0}, "upper nibble");
    end else if (np == 1) begin
      check("R3", pd[0], w[7:0], "byte");
    end else if (np == 2) begin
      check("R4", pd[0], {w[7:4], 4'h0}, "first nibble");
      check("R4", pd[1], {w[3:0], 4'h0}, "second nibble");
      check("R4", prs[1], w[8], "rs second");
      check("R6", pw[1], E, "width second");
    end
    if (np > 0) begin
      check("R3", prs[0], w[8], "rs");
      check("R6", pw[0], E, "width");
    end
    in_valid = 0;
  endtask

  task automatic drain_extra;
    @(negedge clk); #1;
    if (!in_ready) begin
      do begin @(negedge clk); #1; end while (!in_ready);
    end
  endtask

  initial begin
    rw_bad = 0; busy_n = 0; pulse_n = 0; hi_n = 0;
    repeat (3) @(negedge clk);
    #1 rst = 0;
    @(negedge clk); #1;
    check("R1", in_ready, 1, "ready after reset");
    check("R1", lcd_en, 0, "en after reset");
    check("R1", lcd_rs, 0, "rs after reset");
    check("R1", lcd_data, 0, "data after reset");

    send(9'h001, 0, 0); drain_extra();
    send(9'h002, 0, 0); drain_extra();
    send(9'h003, 1, 0); drain_extra();
    send(9'h004, 0, 0); drain_extra();
    send(9'h000, 0, 0); drain_extra();
    send(9'h000, 1, 0); drain_extra();
    send(9'h100, 0, 0); drain_extra();
    send(9'h101, 1, 0); drain_extra();
    send(9'h030, 1, 1); drain_extra();
    send(9'h001, 1, 1); drain_extra();
    send(9'h1A5, 0, 1); drain_extra();
    send(9'h0C3, 1, 0); drain_extra();

    void'($urandom(32'd2468));
    for (int i = 0; i < 60; i++) begin
      logic [8:0] w;
      int k;
      k = $urandom_range(0, 5);
      w = 9'($urandom);
      case (k)
        0: w = {1'b0, 8'($urandom_range(0, 3))};
        1: w = {1'b0, 8'($urandom_range(4, 7))};
        2: w[8] = 1'b1;
        default: ;
      endcase
      send(w, 1'($urandom), 1'($urandom));
      drain_extra();
    end

    check("R2", rw_bad, 0, "rw cycles high");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150_000);
    checks++; fails++;
    $display("FAIL R10 watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule